// File: doc/BRIEF.md
# Paged Memory Expansion Mapper

This block translates the 16-bit CPU address of a home computer into a physical RAM address. The 32 KB memory-expansion area is split into 4 KB windows. Each window can be redirected to any 4 KB page of a 512 KB external RAM. A bank of sixteen 8-bit page registers holds the page numbers. The CPU reaches these registers through a small window at >4000, and only while a control bit is set. A second control bit turns the redirection on. While that bit is clear, every window maps to the page that equals its own index. The 1 KB scratchpad is never paged. It is placed just above the 512 KB paged region.

The two control bits arrive as decoded CRU bit writes: an address, a data bit and a strobe. CPU register writes use a single strobe. They carry only the high byte lane of the data bus. Register reads and address translation are purely combinational. Register and control-bit updates take effect at the clock edge that follows the strobe.

Top module: `paged_mem_mapper`

## Requirements
- R1: After reset, all page registers hold 0 and both control bits are clear. The mapper therefore translates transparently, and the register window is closed.
- R2: A CRU write to address >1E00 loads `cruBit` into the register-access bit at the next clock edge. CRU writes to any other address leave that bit unchanged.
- R3: A CRU write to address >1E02 loads `cruBit` into the mapping-enable bit at the next clock edge.
- R4: While access is on, CPU addresses >4000 to >401F select page register n at byte address >4000+2n, where n is the window index (CPU address bits 15..12). `regRdValid` is 1 exactly in that case.
- R5: A CPU write strobe with a register selected stores `cpuWrHi` (the data bus high byte) into that register. While access is off, the write is ignored.
- R6: `regRdData` returns the stored byte in both bit 15..8 and bit 7..0. Addresses >40(2n) and >40(2n+1) read the same register. While no register is selected, `regRdData` is 0.
- R7: CPU addresses >2000 to >3FFF and >A000 to >FFFF raise `ramSel`, and `physAddr[11:0]` equals `cpuAddr[11:0]`.
- R8: With mapping off, the page part `physAddr[18:12]` of an expansion address equals `cpuAddr[15:12]`, and `physAddr[19]` is 0.
- R9: With mapping on, `physAddr[18:12]` equals bits 6..0 of the window's page register, and register bit 7 is ignored.
- R10: CPU addresses >8000 to >83FF raise `ramSel` and give `physAddr` = >80000 + `cpuAddr[9:0]`, whatever the mapping state.
- R11: Any other CPU address gives `ramSel` = 0 and `physAddr` = 0.
- R12: A CRU write and a CPU access in the same cycle: the CPU access uses the control-bit values from before the CRU write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU byte address |
| cpuWr | input | 1 | CPU write strobe, one cycle |
| cpuWrHi | input | 8 | High byte lane of CPU write data |
| cruWr | input | 1 | Decoded CRU bit write strobe |
| cruAddr | input | 16 | CRU bit address of the write |
| cruBit | input | 1 | CRU bit value |
| regRdValid | output | 1 | A page register is selected |
| regRdData | output | 16 | Selected register, mirrored into both bytes |
| ramSel | output | 1 | Address targets external RAM |
| physAddr | output | 20 | Physical RAM byte address |

## Verification
The coincidence of interest is a control-bit write landing in the same cycle as a CPU access. Two cases are provoked. In the first, the mapping-enable bit is switched on while an expansion address sits on the bus. In the second, register access is switched off in the very cycle a page register is written. In the first case, the translation during the strobe cycle must still be transparent, and it must follow the register one cycle later. In the second case, the write must land, which is confirmed by reopening the window and reading the register back.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  // 64 KB CPU space split into 4 KB windows: the window index is fixed at 4 bits
  localparam int WIN_IDX_W = 4;
  localparam int NUM_WIN   = 1 << WIN_IDX_W;

  typedef enum logic [1:0] {
    AREA_NONE    = 2'd0,
    AREA_EXP     = 2'd1,
    AREA_SCRATCH = 2'd2
  } area_e;

  typedef struct packed {
    logic                 accessOn;
    logic                 mapOn;
    logic                 regHit;
    logic                 regWr;
    logic [WIN_IDX_W-1:0] regIdx;
    logic [WIN_IDX_W-1:0] winIdx;
    area_e                area;
  } ctrlStrb_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
#(
  parameter logic [15:0] CRU_ACCESS_ADDR = 16'h1E00,
  parameter logic [15:0] CRU_MAP_ADDR    = 16'h1E02,
  parameter logic [15:0] REG_BASE        = 16'h4000,
  parameter int          SCR_W           = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:1] cpuAddrW,
  input  logic        cpuWr,
  input  logic        cruWr,
  input  logic [15:0] cruAddr,
  input  logic        cruBit,
  output ctrlStrb_t   strb
);
  localparam int REG_SPAN_W = WIN_IDX_W + 1;  // 16 registers on word spacing
  localparam int SCR_TAG_W  = 16 - SCR_W;
  localparam logic [SCR_TAG_W-1:0] SCR_TAG = SCR_TAG_W'(16'h8000 >> SCR_W);

  logic accessQ;
  logic mapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessQ <= 1'b0;
      mapQ    <= 1'b0;
    end else if (cruWr) begin
      if (cruAddr == CRU_ACCESS_ADDR) accessQ <= cruBit;
      if (cruAddr == CRU_MAP_ADDR)    mapQ    <= cruBit;
    end
  end

  logic         inRegWin;
  logic [2:0]   topBits;
  area_e        areaD;

  always_comb begin
    inRegWin = (cpuAddrW[15:REG_SPAN_W] == REG_BASE[15:REG_SPAN_W]);
    topBits  = cpuAddrW[15:13];
    if ((topBits == 3'b001) || (topBits >= 3'b101))
      areaD = AREA_EXP;
    else if (cpuAddrW[15:SCR_W] == SCR_TAG)
      areaD = AREA_SCRATCH;
    else
      areaD = AREA_NONE;
  end

  always_comb begin
    strb.accessOn = accessQ;
    strb.mapOn    = mapQ;
    strb.regHit   = accessQ && inRegWin;
    strb.regWr    = accessQ && inRegWin && cpuWr;
    strb.regIdx   = cpuAddrW[WIN_IDX_W:1];
    strb.winIdx   = cpuAddrW[15:16-WIN_IDX_W];
    strb.area     = areaD;
  end
endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 12,
  parameter int SCR_W  = 10,
  localparam int PHYS_W = PAGE_W + OFS_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [OFS_W-1:0]  cpuOfs,
  input  logic [REG_W-1:0]  cpuWrHi,
  output logic [2*REG_W-1:0] regRdData,
  output logic              ramSel,
  output logic [PHYS_W-1:0] physAddr
);
  logic [REG_W-1:0] pageReg [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gPageReg
    always_ff @(posedge clk) begin
      if (!rstN)
        pageReg[g] <= '0;
      else if (strb.regWr && (strb.regIdx == WIN_IDX_W'(g)))
        pageReg[g] <= cpuWrHi;
    end
  end

  logic [REG_W-1:0]  selReg;
  logic [REG_W-1:0]  winReg;
  logic [PAGE_W-1:0] page;

  always_comb begin
    selReg    = pageReg[strb.regIdx];
    regRdData = strb.regHit ? {selReg, selReg} : '0;
  end

  always_comb begin
    winReg = pageReg[strb.winIdx];
    if (strb.mapOn)
      page = winReg[PAGE_W-1:0];
    else
      page = PAGE_W'(strb.winIdx);
  end

  always_comb begin
    unique case (strb.area)
      AREA_EXP: begin
        ramSel   = 1'b1;
        physAddr = {1'b0, page, cpuOfs};
      end
      AREA_SCRATCH: begin
        ramSel   = 1'b1;
        physAddr = {1'b1, {(PAGE_W + OFS_W - SCR_W){1'b0}}, cpuOfs[SCR_W-1:0]};
      end
      default: begin
        ramSel   = 1'b0;
        physAddr = '0;
      end
    endcase
  end
endmodule

// File: rtl/paged_mem_mapper.sv
module paged_mem_mapper
  import mapper_pkg::*;
#(
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 12,
  parameter int SCR_W  = 10,
  localparam int REG_W  = 8,
  localparam int PHYS_W = PAGE_W + OFS_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuWr,
  input  logic [REG_W-1:0]  cpuWrHi,
  input  logic              cruWr,
  input  logic [15:0]       cruAddr,
  input  logic              cruBit,
  output logic              regRdValid,
  output logic [2*REG_W-1:0] regRdData,
  output logic              ramSel,
  output logic [PHYS_W-1:0] physAddr
);
  ctrlStrb_t strb;

  mapper_ctrl #(
    .SCR_W(SCR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddrW (cpuAddr[15:1]),
    .cpuWr    (cpuWr),
    .cruWr    (cruWr),
    .cruAddr  (cruAddr),
    .cruBit   (cruBit),
    .strb     (strb)
  );

  mapper_datapath #(
    .REG_W  (REG_W),
    .PAGE_W (PAGE_W),
    .OFS_W  (OFS_W),
    .SCR_W  (SCR_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuOfs    (cpuAddr[OFS_W-1:0]),
    .cpuWrHi   (cpuWrHi),
    .regRdData (regRdData),
    .ramSel    (ramSel),
    .physAddr  (physAddr)
  );

  assign regRdValid = strb.regHit;
endmodule

// File: rtl/paged_mem_mapper_chk.sv
module paged_mem_mapper_chk #(
  parameter int PAGE_W = 7,
  parameter int OFS_W  = 12,
  parameter int SCR_W  = 10,
  localparam int PHYS_W = PAGE_W + OFS_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cpuAddr,
  input logic              cruWr,
  input logic [15:0]       cruAddr,
  input logic              cruBit,
  input logic              regRdValid,
  input logic [15:0]       regRdData,
  input logic              ramSel,
  input logic [PHYS_W-1:0] physAddr,
  input logic              accessOn,
  input logic              mapOn
);
  logic isScr;
  logic isExp;
  assign isScr = (cpuAddr[15:SCR_W] == (16'h8000 >> SCR_W));
  assign isExp = (cpuAddr[15:13] == 3'b001) || (cpuAddr[15:13] >= 3'b101);

  AST_CRU_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (cruWr && cruAddr == 16'h1E00) |=> (accessOn == $past(cruBit))); // R2

  AST_CRU_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (cruWr && cruAddr == 16'h1E02) |=> (mapOn == $past(cruBit))); // R3

  AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    !accessOn |-> !regRdValid); // R4

  AST_RD_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> (regRdData[15:8] == regRdData[7:0])); // R6

  AST_OFS_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    isExp |-> (ramSel && physAddr[OFS_W-1:0] == cpuAddr[OFS_W-1:0])); // R7

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rstN)
    (isExp && !mapOn) |-> (physAddr[PHYS_W-1:OFS_W] == PHYS_W'(cpuAddr[15:12]))); // R8

  AST_SCRATCH_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    isScr |-> (ramSel && physAddr == {1'b1, {(PHYS_W-1-SCR_W){1'b0}}, cpuAddr[SCR_W-1:0]})); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!isExp && !isScr) |-> (!ramSel && physAddr == '0)); // R11
endmodule

bind paged_mem_mapper paged_mem_mapper_chk #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .SCR_W(SCR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cruWr(cruWr),
  .cruAddr(cruAddr), .cruBit(cruBit), .regRdValid(regRdValid),
  .regRdData(regRdData), .ramSel(ramSel), .physAddr(physAddr),
  .accessOn(strb.accessOn), .mapOn(strb.mapOn)
);

// File: tb/paged_mem_mapper_tb_top.sv
module paged_mem_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuWrHi = 8'h00;
  logic        cruWr = 1'b0;
  logic [15:0] cruAddr = 16'h0000;
  logic        cruBit = 1'b0;
  logic        regRdValid;
  logic [15:0] regRdData;
  logic        ramSel;
  logic [19:0] physAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  paged_mem_mapper dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWr(cpuWr), .cpuWrHi(cpuWrHi),
    .cruWr(cruWr), .cruAddr(cruAddr), .cruBit(cruBit), .regRdValid(regRdValid),
    .regRdData(regRdData), .ramSel(ramSel), .physAddr(physAddr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at the falling edge, sample combinational outputs 2 ns later
  task automatic look(input logic [15:0] a);
    @(negedge clk);
    cpuAddr = a;
    #2;
  endtask

  task automatic cruSet(input logic [15:0] a, input logic b);
    @(negedge clk);
    cruWr = 1'b1; cruAddr = a; cruBit = b;
    @(negedge clk);
    cruWr = 1'b0;
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWr = 1'b1; cpuWrHi = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic tReset();
    look(16'h4014);
    chk("R1 window closed after reset", {31'd0, regRdValid}, 32'd0);
    look(16'hA123);
    chk("R1 transparent after reset", {12'd0, physAddr}, 32'h0A123);
    cruSet(16'h1E00, 1'b1);
    look(16'h401E);
    chk("R1 register 15 is zero", {16'd0, regRdData}, 32'h0);
    cruSet(16'h1E00, 1'b0);
  endtask

  task automatic tCru();
    cruSet(16'h1E04, 1'b1);
    look(16'h4014);
    chk("R2 other CRU address ignored", {31'd0, regRdValid}, 32'd0);
    cruSet(16'h1E00, 1'b1);
    look(16'h4014);
    chk("R2 access on", {31'd0, regRdValid}, 32'd1);
    look(16'h4020);
    chk("R4 past window end", {31'd0, regRdValid}, 32'd0);
  endtask

  task automatic tRegs();
    regWrite(16'h4014, 8'h85);           // window A
    regWrite(16'h4004, 8'h11);           // window 2
    regWrite(16'h401E, 8'h7F);           // window F
    look(16'h4014);
    chk("R5 R6 reg A mirrored", {16'd0, regRdData}, 32'h8585);
    look(16'h4015);
    chk("R6 odd byte same", {16'd0, regRdData}, 32'h8585);
    look(16'h401E);
    chk("R4 reg F", {16'd0, regRdData}, 32'h7F7F);
    look(16'h2000);
    chk("R6 no select reads zero", {16'd0, regRdData}, 32'h0);
    cruSet(16'h1E00, 1'b0);
    regWrite(16'h4014, 8'h22);
    cruSet(16'h1E00, 1'b1);
    look(16'h4014);
    chk("R5 write with access off ignored", {16'd0, regRdData}, 32'h8585);
  endtask

  task automatic tTranslate();
    look(16'h2ABC);
    chk("R8 transparent window 2", {12'd0, physAddr}, 32'h02ABC);
    chk("R7 ramSel expansion", {31'd0, ramSel}, 32'd1);
    cruSet(16'h1E02, 1'b1);
    look(16'hA123);
    chk("R9 mapped, bit7 ignored", {12'd0, physAddr}, 32'h05123);
    look(16'h2ABC);
    chk("R9 mapped window 2", {12'd0, physAddr}, 32'h11ABC);
    look(16'hFFFF);
    chk("R9 R7 mapped window F", {12'd0, physAddr}, 32'h7FFFF);
    look(16'h3001);
    chk("R9 unwritten reg gives page 0", {12'd0, physAddr}, 32'h00001);
    look(16'h8302);
    chk("R10 scratch mapped mode", {12'd0, physAddr}, 32'h80302);
    look(16'h83FF);
    chk("R10 scratch top", {12'd0, physAddr}, 32'h803FF);
    look(16'h8400);
    chk("R11 above scratch", {11'd0, ramSel, physAddr}, 32'h0);
    look(16'h4014);
    chk("R11 register window not RAM", {31'd0, ramSel}, 32'd0);
    look(16'h0100);
    chk("R11 low ROM", {11'd0, ramSel, physAddr}, 32'h0);
    cruSet(16'h1E02, 1'b0);
    look(16'h8010);
    chk("R10 scratch unmapped mode", {12'd0, physAddr}, 32'h80010);
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    cpuAddr = 16'hA123; cruWr = 1'b1; cruAddr = 16'h1E02; cruBit = 1'b1;
    #2;
    chk("R12 old mode during CRU strobe", {12'd0, physAddr}, 32'h0A123);
    @(negedge clk);
    cruWr = 1'b0;
    #2;
    chk("R12 new mode next cycle", {12'd0, physAddr}, 32'h05123);
    @(negedge clk);
    cpuAddr = 16'h401E; cpuWr = 1'b1; cpuWrHi = 8'h3C;
    cruWr = 1'b1; cruAddr = 16'h1E00; cruBit = 1'b0;
    @(negedge clk);
    cpuWr = 1'b0; cruWr = 1'b0;
    #2;
    chk("R12 access closed after strobe", {31'd0, regRdValid}, 32'd0);
    cruSet(16'h1E00, 1'b1);
    look(16'h401E);
    chk("R12 write landed with old access", {16'd0, regRdData}, 32'h3C3C);
    look(16'hF00F);
    chk("R9 new page used", {12'd0, physAddr}, 32'h3C00F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCru();
    tRegs();
    tTranslate();
    tSameCycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule